// File: doc/BRIEF.md
# Parallel-Port Peripheral Mailbox and Data Source Selector

This block sits on the device side of a byte-wide parallel port. Two host control lines decide what the device returns on the data lines: the current byte from sample channel A, the current byte from sample channel B, the mailbox, or a fixed identification byte. The host reads that identification byte to find out whether the device is present. The device drives the data lines only while the host has turned its own data direction to input.

The mailbox is a single byte that the host and an internal controller share in half-duplex fashion. A zero byte means the mailbox is empty, so a side never sees its own byte come back: each side reads zero until the other side writes. For the same reason a zero byte cannot be sent. A host strobe edge does one of two things. With a sample channel selected, it moves the shared sample read address forward. With the mailbox selected and the write qualifier active, it writes the mailbox. Every host control input passes through a synchronizer, and the data lines are registered, so the returned byte settles a few clock cycles after the controls change.

Top module: `ppmb_port_if`

## Requirements
- R1: The source is chosen from {host_selin, host_autofd}, both active high. 00 gives chan_a_data, 01 gives chan_b_data, 10 gives the host view of the mailbox, and 11 gives the constant ID_BYTE (default 0x55).
- R2: host_data_oe is high only while host_dir_in is high. With host_dir_in low it is low.
- R3: A rising edge of host_strobe while the code is 10 and host_init is high stores a non-zero host_data_in in the mailbox and raises mbox_full.
- R4: After a host write, the host view of the mailbox reads 0x00 and ctl_rdata shows the byte.
- R5: A one-cycle pulse on ctl_rd clears mbox_full. The host byte stays readable on ctl_rdata.
- R6: A pulse on ctl_wr with a non-zero ctl_wdata replaces the mailbox. The host view then shows that byte, ctl_rdata reads 0x00 and mbox_full is low.
- R7: A zero byte written by either side leaves the mailbox contents, its direction and mbox_full unchanged.
- R8: Each rising edge of host_strobe while the code is 00 or 01 advances rd_addr by one. rd_addr wraps from DEPTH-1 to 0.
- R9: A strobe edge while the code is 11, or while the code is 10 with host_init low, leaves both rd_addr and the mailbox unchanged.
- R10: After reset, rd_addr is 0, mbox_full is low, host_data_oe is low, and the mailbox reads 0x00 from both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_dir_in | input | 1 | Host data direction is input, so the device may drive |
| host_autofd | input | 1 | Source select bit 0, active high |
| host_selin | input | 1 | Source select bit 1, active high |
| host_strobe | input | 1 | Host strobe, acts on the rising edge |
| host_init | input | 1 | Mailbox write qualifier |
| host_data_in | input | DW | Byte the host drives on the data lines |
| host_data_out | output | DW | Byte the device returns |
| host_data_oe | output | 1 | Device drive enable for the data lines |
| chan_a_data | input | DW | Sample byte of channel A at rd_addr |
| chan_b_data | input | DW | Sample byte of channel B at rd_addr |
| rd_addr | output | AW | Sample read address |
| ctl_wr | input | 1 | Controller mailbox write pulse |
| ctl_wdata | input | DW | Controller write byte |
| ctl_rd | input | 1 | Controller read acknowledge pulse |
| ctl_rdata | output | DW | Controller view of the mailbox |
| mbox_full | output | 1 | A host byte is waiting for the controller |

## Verification
The hardest case to reach from the ports is the wrap of rd_addr. The bench builds the block with a small DEPTH and sends enough strobes, on both sample channels, to cross the last address. Zero writes also need care, because their effect can only be seen when the mailbox already holds a byte from the other side. The bench therefore loads a controller byte first, sends zero from each side, and checks that the host view and mbox_full have not changed.

// File: rtl/ppmb_pkg.sv
package ppmb_pkg;
   // source code is {selin, autofd}
   typedef enum logic [1:0] {
      SRC_CHAN_A = 2'b00,
      SRC_CHAN_B = 2'b01,
      SRC_MBOX   = 2'b10,
      SRC_IDENT  = 2'b11
   } src_e;
endpackage

// File: rtl/ppmb_sync.sv
module ppmb_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (STAGES >= 1 && STAGES <= 4)
      else $error("ppmb_sync: STAGES out of range");

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ppmb_readptr.sv
module ppmb_readptr #(
   parameter int DEPTH = 1024,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   initial assert (DEPTH >= 2) else $error("ppmb_readptr: DEPTH too small");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (step)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   // R8: one strobe, one step, with wrap
   p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));
   // R9: no step, no motion
   p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(ptr));
endmodule

// File: rtl/ppmb_mbox.sv
module ppmb_mbox #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic [DW-1:0] host_wdata,
   input  logic          ctl_we,
   input  logic [DW-1:0] ctl_wdata,
   input  logic          ctl_re,
   output logic [DW-1:0] host_view,
   output logic [DW-1:0] ctl_view,
   output logic          full
);
   logic [DW-1:0] held;
   logic          loaded;
   logic          by_host;

   wire ctl_ok  = ctl_we  && (ctl_wdata  != '0);
   wire host_ok = host_we && (host_wdata != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held    <= '0;
         loaded  <= 1'b0;
         by_host <= 1'b0;
         full    <= 1'b0;
      end else if (ctl_ok) begin
         held    <= ctl_wdata;
         loaded  <= 1'b1;
         by_host <= 1'b0;
         full    <= 1'b0;
      end else if (host_ok) begin
         held    <= host_wdata;
         loaded  <= 1'b1;
         by_host <= 1'b1;
         full    <= 1'b1;
      end else if (ctl_re) begin
         full    <= 1'b0;
      end
   end

   assign host_view = (loaded && !by_host) ? held : '0;
   assign ctl_view  = (loaded &&  by_host) ? held : '0;

   // R5: acknowledge clears the flag unless a fresh host byte lands
   p_full_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_re && !host_ok) |=> !full);
   // R7: zero bytes alone never alter what either side sees
   p_zero_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_ok && !host_ok && !ctl_re) |=> $stable(host_view) && $stable(ctl_view) && $stable(full));
   // R4: a side never reads back its own byte
   p_one_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_view == '0) || (ctl_view == '0));
endmodule

// File: rtl/ppmb_port_if.sv
module ppmb_port_if #(
   parameter int           DW          = 8,
   parameter int           DEPTH       = 1024,
   parameter int           SYNC_STAGES = 2,
   parameter logic [DW-1:0] ID_BYTE    = DW'(8'h55),
   localparam int          AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_dir_in,
   input  logic          host_autofd,
   input  logic          host_selin,
   input  logic          host_strobe,
   input  logic          host_init,
   input  logic [DW-1:0] host_data_in,
   output logic [DW-1:0] host_data_out,
   output logic          host_data_oe,
   input  logic [DW-1:0] chan_a_data,
   input  logic [DW-1:0] chan_b_data,
   output logic [AW-1:0] rd_addr,
   input  logic          ctl_wr,
   input  logic [DW-1:0] ctl_wdata,
   input  logic          ctl_rd,
   output logic [DW-1:0] ctl_rdata,
   output logic          mbox_full
);
   import ppmb_pkg::*;

   initial assert (DW >= 8) else $error("ppmb_port_if: DW below 8");

   localparam int NCTL = 5;
   logic [NCTL-1:0] ctl_raw, ctl_s;
   assign ctl_raw = {host_dir_in, host_autofd, host_selin, host_strobe, host_init};

   ppmb_sync #(.W(NCTL), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s));

   wire s_dir    = ctl_s[4];
   wire s_autofd = ctl_s[3];
   wire s_selin  = ctl_s[2];
   wire s_stb    = ctl_s[1];
   wire s_init   = ctl_s[0];

   src_e src;
   assign src = src_e'({s_selin, s_autofd});

   logic stb_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= s_stb;
   end
   wire stb_rise = s_stb && !stb_q;

   wire step    = stb_rise && (src == SRC_CHAN_A || src == SRC_CHAN_B);
   wire host_we = stb_rise && (src == SRC_MBOX) && s_init;

   ppmb_readptr #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .step(step), .ptr(rd_addr));

   logic [DW-1:0] host_view;
   ppmb_mbox #(.DW(DW)) u_mbox (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_wdata(host_data_in),
      .ctl_we(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_re(ctl_rd),
      .host_view(host_view), .ctl_view(ctl_rdata), .full(mbox_full));

   logic [DW-1:0] sel_byte;
   always_comb begin
      unique case (src)
         SRC_CHAN_A: sel_byte = chan_a_data;
         SRC_CHAN_B: sel_byte = chan_b_data;
         SRC_MBOX:   sel_byte = host_view;
         default:    sel_byte = ID_BYTE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_data_out <= '0;
         host_data_oe  <= 1'b0;
      end else begin
         host_data_out <= sel_byte;
         host_data_oe  <= s_dir;
      end
   end

   // R2: drive enable follows the synchronized host direction
   p_oe_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !s_dir |=> !host_data_oe);
   // R1: identification code yields the constant
   p_ident_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_IDENT) |=> host_data_out == ID_BYTE);
   // R9: the identification code never writes the mailbox
   p_no_write_ident_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_IDENT) |=> $stable(mbox_full) || $past(ctl_rd) || $past(ctl_wr));
endmodule

// File: tb/ppmb_port_if_tb.sv
module ppmb_port_if_tb;
   localparam int DW    = 8;
   localparam int DEPTH = 16;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_dir_in = 0, host_autofd = 0, host_selin = 0;
   logic          host_strobe = 0, host_init = 0;
   logic [DW-1:0] host_data_in = '0;
   logic [DW-1:0] host_data_out;
   logic          host_data_oe;
   logic [DW-1:0] chan_a_data = 8'hA1, chan_b_data = 8'hB2;
   logic [AW-1:0] rd_addr;
   logic          ctl_wr = 0, ctl_rd = 0;
   logic [DW-1:0] ctl_wdata = '0;
   logic [DW-1:0] ctl_rdata;
   logic          mbox_full;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   ppmb_port_if #(.DW(DW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_dir_in(host_dir_in), .host_autofd(host_autofd), .host_selin(host_selin),
      .host_strobe(host_strobe), .host_init(host_init), .host_data_in(host_data_in),
      .host_data_out(host_data_out), .host_data_oe(host_data_oe),
      .chan_a_data(chan_a_data), .chan_b_data(chan_b_data), .rd_addr(rd_addr),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd),
      .ctl_rdata(ctl_rdata), .mbox_full(mbox_full));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic set_src(input logic selin, input logic autofd);
      host_selin  = selin;
      host_autofd = autofd;
      settle();
   endtask

   task automatic pulse_strobe();
      host_strobe = 1'b1;
      settle();
      host_strobe = 1'b0;
      settle();
   endtask

   task automatic host_write(input logic [DW-1:0] b);
      host_data_in = b;
      host_init    = 1'b1;
      set_src(1'b1, 1'b0);
      pulse_strobe();
      host_init    = 1'b0;
      settle();
   endtask

   task automatic ctl_write(input logic [DW-1:0] b);
      ctl_wdata = b;
      ctl_wr    = 1'b1;
      @(negedge clk);
      ctl_wr    = 1'b0;
      settle();
   endtask

   task automatic t_reset();
      check("R10 oe", host_data_oe, 0);
      check("R10 rd_addr", rd_addr, 0);
      check("R10 full", mbox_full, 0);
      check("R10 ctl_rdata", ctl_rdata, 0);
   endtask

   task automatic t_select();
      host_dir_in = 1'b1;
      set_src(1'b0, 1'b0);
      check("R1 chan A", host_data_out, 8'hA1);
      check("R2 oe on", host_data_oe, 1);
      set_src(1'b0, 1'b1);
      check("R1 chan B", host_data_out, 8'hB2);
      set_src(1'b1, 1'b1);
      check("R1 ident", host_data_out, 8'h55);
      set_src(1'b1, 1'b0);
      check("R10 mbox empty host", host_data_out, 8'h00);
      host_dir_in = 1'b0;
      settle();
      check("R2 oe off", host_data_oe, 0);
      host_dir_in = 1'b1;
      settle();
   endtask

   task automatic t_pointer();
      set_src(1'b0, 1'b0);
      for (int i = 0; i < 3; i++) pulse_strobe();
      check("R8 chan A steps", rd_addr, 3);
      set_src(1'b0, 1'b1);
      pulse_strobe();
      check("R8 chan B step", rd_addr, 4);
      set_src(1'b1, 1'b1);
      pulse_strobe();
      check("R9 ident no step", rd_addr, 4);
      set_src(1'b1, 1'b0);
      host_init    = 1'b0;
      host_data_in = 8'h77;
      pulse_strobe();
      check("R9 mbox no init ptr", rd_addr, 4);
      check("R9 mbox no init full", mbox_full, 0);
      check("R9 mbox no init view", ctl_rdata, 0);
      set_src(1'b0, 1'b0);
      for (int i = 0; i < DEPTH - 5; i++) pulse_strobe();
      check("R8 last addr", rd_addr, DEPTH - 1);
      pulse_strobe();
      check("R8 wrap", rd_addr, 0);
   endtask

   task automatic t_host_write();
      host_write(8'h3C);
      check("R3 full set", mbox_full, 1);
      check("R4 ctl sees byte", ctl_rdata, 8'h3C);
      check("R4 host reads zero", host_data_out, 8'h00);
      check("R9 mbox write no step", rd_addr, 0);
      ctl_rd = 1'b1;
      @(negedge clk);
      ctl_rd = 1'b0;
      settle();
      check("R5 full cleared", mbox_full, 0);
      check("R5 byte kept", ctl_rdata, 8'h3C);
   endtask

   task automatic t_ctl_write();
      ctl_write(8'h9D);
      check("R6 host sees byte", host_data_out, 8'h9D);
      check("R6 ctl reads zero", ctl_rdata, 8'h00);
      check("R6 full low", mbox_full, 0);
   endtask

   task automatic t_zero();
      host_write(8'h00);
      check("R7 host zero view", host_data_out, 8'h9D);
      check("R7 host zero full", mbox_full, 0);
      ctl_write(8'h00);
      check("R7 ctl zero view", host_data_out, 8'h9D);
      check("R7 ctl zero ctl", ctl_rdata, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_select();
      t_pointer();
      t_host_write();
      t_ctl_write();
      t_zero();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule